// File: doc/BRIEF.md
# Multiplexed Address/Data Port Controller

This block is the host side of an external parallel bus. Sixteen shared pins carry both address and data. An address latch enable strobe, plus active-low read and write strobes, mark what the pins hold. An internal requester hands over one word access at a time through a valid/ready handshake, with a 24-bit address and write data. The controller runs the bus cycle and returns read data as a one-cycle valid pulse.

Every bus cycle has up to three parts:
- an optional one-clock address phase;
- a strobe phase of programmable length;
- one turnaround clock.

The address phase is skipped when the tracked address bits match what is already held in the external latch. In 16-bit mode the tracked bits are the low sixteen. In 8-bit mode they are the upper sixteen, because the low address byte travels on the upper pin byte during the data phase. This saves one clock on every access that stays inside the same latched window.

The latch enable polarity is selectable. The pins can also be handed over to a flag mode. In that mode each pin is an individually directed general-purpose I/O, and all three strobes stay at rest.

Top module: `adbus_port`

## Requirements
- R1: `req_ready` is high only while the port is enabled (`cfg_port_en`=1) and no bus cycle is in progress. It drops in the cycle after a request is accepted and returns high in the cycle after the turnaround clock.
- R2: In 16-bit mode (`cfg_wide`=1), an access whose address bits 15..0 differ from the last latched value takes one address-phase clock. During that clock the latch strobe is asserted, all pins are driven, and the pins carry address bits 15..0. An access with matching bits 15..0 skips the address phase, whatever its bits 23..16 are.
- R3: In 8-bit mode (`cfg_wide`=0), an address phase is taken only when address bits 23..8 differ from the last latched value. The pins then carry address bits 23..8.
- R4: After reset, or after any change of `cfg_wide` or `cfg_port_en`, the next accepted access always takes an address phase.
- R5: The strobe phase lasts `cfg_wait`+1 clocks. `rd_n` is low through it for a read and `wr_n` is low through it for a write. Otherwise both are high, and they are never low together.
- R6: During a write strobe all pins are driven. In 16-bit mode they carry the write data. In 8-bit mode the upper byte carries address bits 7..0 and the lower byte carries write data bits 7..0.
- R7: During a read strobe, 16-bit mode releases all pins. 8-bit mode drives only the upper byte, with address bits 7..0 (`ad_oe`=16'hFF00). `ad_i` is captured on the edge that ends the strobe phase. `rsp_valid` is high for exactly the following clock, with `rsp_rdata` equal to `ad_i` (16-bit mode) or to `ad_i[7:0]` zero-extended (8-bit mode).
- R8: With `cfg_ale_low`=0 the latch strobe is high when asserted and low at rest. With `cfg_ale_low`=1 it is low when asserted and high at rest.
- R9: Flag mode is selected by `cfg_flag_sel`=1 with `cfg_port_en`=0. In flag mode `ad_oe`=`flag_dir`, `ad_o`=`flag_out`, `flag_in`=`ad_i`, `rd_n`=`wr_n`=1, the latch strobe rests, and requests are not accepted.
- R10: The clock after the strobe phase is a turnaround clock. All pins are released and all strobes are at rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_port_en | input | 1 | Port enable |
| cfg_flag_sel | input | 1 | Flag mode select (effective when port disabled) |
| cfg_wide | input | 1 | 1 = 16-bit data mode, 0 = 8-bit data mode |
| cfg_ale_low | input | 1 | 1 = latch strobe active low |
| cfg_wait | input | 3 | Strobe length minus one |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data |
| flag_dir | input | 16 | Per-pin output enable in flag mode |
| flag_out | input | 16 | Per-pin output value in flag mode |
| flag_in | output | 16 | Pin values seen in flag mode |
| ad_i | input | 16 | Pin input values |
| ad_o | output | 16 | Pin output values |
| ad_oe | output | 16 | Per-pin output enable |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Call the accept edge the one where valid and ready are both high. The address phase, when it is taken, occupies the first clock after that edge. The strobe clocks follow, and `rsp_valid` lines up with the turnaround clock. `req_ready` returns one clock later. The bench drives a request, steps one falling edge past the accept edge, and then checks the pins and strobes at every falling edge through the expected sequence. The expected number of address clocks and strobe clocks is taken from the vector table, so a phase that is missing or a clock too long shows up as a miscompare at a fixed falling edge. Flag mode involves no registers, so it is checked in the same cycle as the stimulus.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ADDR   = 2'd1,
    ST_STROBE = 2'd2,
    ST_TURN   = 2'd3
  } bus_state_e;
endpackage

// File: rtl/adbus_tag_track.sv
module adbus_tag_track #(
  parameter int TAG_W = 16,
  parameter int KEY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] mode_key,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             load,
  output logic             need_latch,
  output logic             mode_chg
);
  logic [TAG_W-1:0] last_q;
  logic [KEY_W-1:0] key_q;
  logic             valid_q;

  assign mode_chg   = (mode_key != key_q);
  assign need_latch = !valid_q || mode_chg || (tag_in != last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      key_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      key_q <= mode_key;
      if (load) begin
        last_q  <= tag_in;
        valid_q <= 1'b1;
      end else if (mode_chg) begin
        valid_q <= 1'b0;
      end
    end
  end

  // R4: a mode change with no new latch leaves no usable stored tag
  p_inval_on_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && !load) |=> need_latch);
  // R2: right after a latch, the same tag under the same mode needs none
  p_tag_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !mode_chg) |=> ($stable(mode_key) && $stable(tag_in)) |-> !need_latch);
endmodule

// File: rtl/adbus_seq.sv
module adbus_seq
  import adbus_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              need_latch,
  input  logic [WAIT_W-1:0] wait_cfg,
  output bus_state_e        state,
  output logic              strobe_last
);
  bus_state_e        st_q;
  logic [WAIT_W-1:0] cnt_q;

  assign state       = st_q;
  assign strobe_last = (st_q == ST_STROBE) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go) begin
          cnt_q <= wait_cfg;
          st_q  <= need_latch ? ST_ADDR : ST_STROBE;
        end
        ST_ADDR:   st_q <= ST_STROBE;
        ST_STROBE: begin
          if (cnt_q == '0) st_q <= ST_TURN;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_TURN:   st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  // R2: the address phase is exactly one clock and leads into the strobe
  p_addr_one_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR) |=> (st_q == ST_STROBE));
  // R5: the strobe phase continues until its counter is exhausted
  p_strobe_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STROBE && cnt_q != '0) |=> (st_q == ST_STROBE));
  // R10: the strobe phase always ends in one turnaround clock
  p_turn_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_last |=> (st_q == ST_TURN) ##1 (st_q == ST_IDLE));
endmodule

// File: rtl/adbus_port.sv
module adbus_port
  import adbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int AD_W   = 16,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_port_en,
  input  logic              cfg_flag_sel,
  input  logic              cfg_wide,
  input  logic              cfg_ale_low,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [AD_W-1:0]   req_wdata,
  output logic              rsp_valid,
  output logic [AD_W-1:0]   rsp_rdata,
  input  logic [AD_W-1:0]   flag_dir,
  input  logic [AD_W-1:0]   flag_out,
  output logic [AD_W-1:0]   flag_in,
  input  logic [AD_W-1:0]   ad_i,
  output logic [AD_W-1:0]   ad_o,
  output logic [AD_W-1:0]   ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);
  localparam int BYTE_W = AD_W / 2;

  // tracked address bits: low word when wide, upper bits when narrow
  function automatic logic [AD_W-1:0] tag_of(input logic [ADDR_W-1:0] a,
                                             input logic wide);
    return wide ? a[AD_W-1:0] : a[ADDR_W-1 -: AD_W];
  endfunction

  // pin value during a write strobe
  function automatic logic [AD_W-1:0] wr_drive(input logic [ADDR_W-1:0] a,
                                               input logic [AD_W-1:0] d,
                                               input logic wide);
    return wide ? d : {a[BYTE_W-1:0], d[BYTE_W-1:0]};
  endfunction

  // data returned from the pins
  function automatic logic [AD_W-1:0] rd_take(input logic [AD_W-1:0] p,
                                              input logic wide);
    return wide ? p : {{BYTE_W{1'b0}}, p[BYTE_W-1:0]};
  endfunction

  bus_state_e        state;
  logic              strobe_last;
  logic              need_latch;
  logic              mode_chg;
  logic              flag_mode;
  logic              accept;
  logic              ev_addr, ev_strobe;
  logic              wr_q, wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic [AD_W-1:0]   wdata_q;

  assign flag_mode = cfg_flag_sel && !cfg_port_en;
  assign req_ready = cfg_port_en && (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign ev_addr   = (state == ST_ADDR);
  assign ev_strobe = (state == ST_STROBE);

  adbus_tag_track #(.TAG_W(AD_W), .KEY_W(2)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_key   ({cfg_wide, cfg_port_en}),
    .tag_in     (tag_of(req_addr, cfg_wide)),
    .load       (accept && need_latch),
    .need_latch (need_latch),
    .mode_chg   (mode_chg)
  );

  adbus_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (accept),
    .need_latch  (need_latch),
    .wait_cfg    (cfg_wait),
    .state       (state),
    .strobe_last (strobe_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      wide_q  <= 1'b1;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      wide_q  <= cfg_wide;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= strobe_last && !wr_q;
      if (strobe_last && !wr_q) rsp_rdata <= rd_take(ad_i, wide_q);
    end
  end

  always_comb begin
    ad_o    = '0;
    ad_oe   = '0;
    flag_in = '0;
    if (flag_mode) begin
      ad_o    = flag_out;
      ad_oe   = flag_dir;
      flag_in = ad_i;
    end else if (ev_addr) begin
      ad_o  = tag_of(addr_q, wide_q);
      ad_oe = '1;
    end else if (ev_strobe && wr_q) begin
      ad_o  = wr_drive(addr_q, wdata_q, wide_q);
      ad_oe = '1;
    end else if (ev_strobe && !wide_q) begin
      ad_o  = {addr_q[BYTE_W-1:0], {BYTE_W{1'b0}}};
      ad_oe = {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}};
    end
  end

  assign ale  = ev_addr ^ cfg_ale_low;
  assign rd_n = !(ev_strobe && !wr_q);
  assign wr_n = !(ev_strobe && wr_q);

  // R5: read and write strobes are never active together
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  // R9: flag mode keeps every strobe at rest
  p_flag_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_mode |-> (rd_n && wr_n && (ale == cfg_ale_low) && !req_ready));
  // R1: an accepted request blocks the next one for at least a cycle
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R7: read data valid is a single-cycle pulse
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10: pins are released in the clock after the strobe phase
  p_turn_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_last && !flag_mode) |=> (ad_oe == '0 || flag_mode));
endmodule

// File: tb/adbus_port_bench.sv
module adbus_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_port_en = 1'b1, cfg_flag_sel = 1'b0, cfg_wide = 1'b1, cfg_ale_low = 1'b0;
  logic [2:0]  cfg_wait = 3'd0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0, flag_dir = '0, flag_out = '0, ad_i = '0;
  logic        req_ready, rsp_valid, ale, rd_n, wr_n;
  logic [15:0] rsp_rdata, flag_in, ad_o, ad_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adbus_port u_adbus_port (
    .clk(clk), .rst_n(rst_n), .cfg_port_en(cfg_port_en), .cfg_flag_sel(cfg_flag_sel),
    .cfg_wide(cfg_wide), .cfg_ale_low(cfg_ale_low), .cfg_wait(cfg_wait),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .flag_dir(flag_dir), .flag_out(flag_out),
    .flag_in(flag_in), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  // {write, wide, wait, expect_latch, addr, wdata, pin_data}
  localparam logic [61:0] VEC [0:NVEC-1] = '{
    {1'b1, 1'b1, 3'd0, 1'b1, 24'h000010, 16'h1234, 16'h0000},
    {1'b0, 1'b1, 3'd2, 1'b0, 24'h000010, 16'h0000, 16'hABCD},
    {1'b1, 1'b1, 3'd1, 1'b0, 24'h120010, 16'h5A5A, 16'h0000},
    {1'b0, 1'b1, 3'd0, 1'b1, 24'h000011, 16'h0000, 16'h8001},
    {1'b1, 1'b0, 3'd1, 1'b1, 24'h345678, 16'h99EE, 16'h0000},
    {1'b0, 1'b0, 3'd3, 1'b0, 24'h3456AA, 16'h0000, 16'h55C3},
    {1'b1, 1'b0, 3'd7, 1'b1, 24'h3457AA, 16'h0F1E, 16'h0000},
    {1'b0, 1'b0, 3'd0, 1'b0, 24'h3457FF, 16'h0000, 16'h7E81},
    {1'b1, 1'b1, 3'd0, 1'b1, 24'h0000FF, 16'hCAFE, 16'h0000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic access(input bit wr, input bit wide, input logic [2:0] w,
                        input bit latch, input logic [23:0] a,
                        input logic [15:0] d, input logic [15:0] pin);
    logic [15:0] tag, wexp, rexp;
    tag  = wide ? a[15:0] : a[23:8];
    wexp = wide ? d : {a[7:0], d[7:0]};
    rexp = wide ? pin : {8'h00, pin[7:0]};
    @(negedge clk);
    cfg_wide = wide; cfg_wait = w; ad_i = pin;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    chk(req_ready == 1'b1, "R1 ready idle", {31'd0, req_ready}, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 ready busy", {31'd0, req_ready}, 0);
    if (latch) begin
      chk(ale == !cfg_ale_low, "R8 ale asserted", {31'd0, ale}, {31'd0, !cfg_ale_low});
      chk(ad_o == tag && ad_oe == 16'hFFFF, wide ? "R2 addr phase" : "R3 addr phase",
          {ad_oe, ad_o}, {16'hFFFF, tag});
      @(negedge clk);
    end
    chk(ale == cfg_ale_low, wide ? "R2 ale rest" : "R3 ale rest", {31'd0, ale},
        {31'd0, cfg_ale_low});
    for (int i = 0; i <= int'(w); i++) begin
      chk(rd_n == wr && wr_n == !wr, "R5 strobe", {30'd0, rd_n, wr_n}, {30'd0, wr, !wr});
      if (wr)
        chk(ad_o == wexp && ad_oe == 16'hFFFF, "R6 write drive", {ad_oe, ad_o},
            {16'hFFFF, wexp});
      else if (wide)
        chk(ad_oe == 16'h0000, "R7 read release", {16'h0, ad_oe}, 0);
      else
        chk(ad_oe == 16'hFF00 && ad_o[15:8] == a[7:0], "R7 narrow read drive",
            {ad_oe, ad_o}, {16'hFF00, a[7:0], ad_o[7:0]});
      if (i < int'(w)) @(negedge clk);
    end
    @(negedge clk);
    chk(rd_n && wr_n && ad_oe == 16'h0, "R10 turnaround", {14'd0, rd_n, wr_n, ad_oe},
        {14'd0, 2'b11, 16'h0});
    chk(rsp_valid == !wr, "R7 rsp_valid", {31'd0, rsp_valid}, {31'd0, !wr});
    if (!wr) chk(rsp_rdata == rexp, "R7 read data", {16'h0, rsp_rdata}, {16'h0, rexp});
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R1 R7 back to idle", {30'd0, rsp_valid, req_ready},
        {30'd0, 2'b01});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // reset state
    chk(rd_n && wr_n && !ale && ad_oe == 0 && !rsp_valid, "R5 R8 reset outputs",
        {12'd0, rd_n, wr_n, ale, rsp_valid, ad_oe}, {12'd0, 4'b1100, 16'h0});
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", {31'd0, req_ready}, 1);

    for (int v = 0; v < NVEC; v++)
      access(VEC[v][61], VEC[v][60], VEC[v][59:57], VEC[v][56], VEC[v][55:32],
             VEC[v][31:16], VEC[v][15:0]);

    // R8: active-low latch strobe
    @(negedge clk);
    cfg_ale_low = 1'b1;
    @(negedge clk);
    chk(ale == 1'b1, "R8 ale low rest", {31'd0, ale}, 1);
    access(1'b0, 1'b1, 3'd1, 1'b1, 24'h000123, 16'h0, 16'h2468);
    cfg_ale_low = 1'b0;

    // R1: port disabled refuses requests
    @(negedge clk);
    cfg_port_en = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    chk(!req_ready && rd_n && wr_n, "R1 disabled", {30'd0, req_ready, rd_n}, {30'd0, 2'b01});
    req_valid = 1'b0;

    // R9: flag mode
    cfg_flag_sel = 1'b1; flag_dir = 16'hF0F0; flag_out = 16'h1234; ad_i = 16'hABCD;
    req_valid = 1'b1;
    #1;
    chk(ad_oe == 16'hF0F0 && ad_o == 16'h1234, "R9 flag drive", {ad_oe, ad_o},
        {16'hF0F0, 16'h1234});
    chk(flag_in == 16'hABCD, "R9 flag input", {16'h0, flag_in}, {16'h0, 16'hABCD});
    repeat (3) @(negedge clk);
    chk(rd_n && wr_n && !ale && !req_ready, "R9 flag strobes rest",
        {28'd0, rd_n, wr_n, ale, req_ready}, {28'd0, 4'b1100});
    req_valid = 1'b0;
    cfg_flag_sel = 1'b0;
    cfg_port_en = 1'b1;
    // R4: same address as last latched, but port was re-enabled
    access(1'b1, 1'b1, 3'd0, 1'b1, 24'h000123, 16'h4321, 16'h0);

    // R4: reset invalidates the stored address
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 1'b1, 3'd0, 1'b1, 24'h000123, 16'h0, 16'h1357);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule